// File: doc/BRIEF.md
# Erased-Sector Parity Filter

The block sits between a Reed-Solomon parity engine for 512-byte sectors and the host side of a flash controller. It has two independent paths. The encode path takes the nine parity bytes that the generator produces for a sector and compares them, one per cycle, against the fixed signature that an all-0xFF sector yields (CD 9D 90 58 F4 8B FF B7 6F, byte 0 first). If all nine match, the block replays the group as nine 0xFF bytes. An erased page then keeps blank parity, and later partial-page programming stays possible. Any other group is replayed unchanged.

The scan path takes a sector as it is read back. The stored parity comes first and the data follows it. The path watches for any byte other than 0xFF. If the whole sector and its parity are blank, it reports the sector as erased with zero errors and raises no decode request, so the decoder never runs. Otherwise it requests a decode. A sticky quick-reject flag marks a failure at the probe positions (parity byte 0, and data bytes 0, 255 and 511) as soon as one is seen.

Encode-path states: `WR_IDLE` (waiting for a group start), `WR_COLLECT` (taking parity bytes 1 to 8), and `WR_EMIT` (replaying nine bytes). The transitions are idle→collect on a start byte, collect→emit on the ninth byte, collect→collect on a new start byte (the group restarts), and emit→idle after the ninth replayed byte. Scan-path states: `RD_IDLE`, `RD_PARITY` (stored parity bytes), `RD_DATA` (data bytes) and `RD_VERDICT` (one cycle). The transitions are idle→parity on a start byte, parity→data after parity byte 8, any open state→verdict on an end-marked byte, verdict→idle, and any state→parity on a start byte.

Top module: `erased_ecc_filter`

## Requirements
- R1: When the nine encode bytes, taken from the byte marked first, equal CD 9D 90 58 F4 8B FF B7 6F in that order, all nine replayed bytes are 0xFF and `enc_out_blanked` is 1 throughout the replay.
- R2: When any of the nine encode bytes differs from that signature, the replay carries the nine input bytes unchanged and in arrival order, and `enc_out_blanked` is 0.
- R3: The replay starts in the cycle after the ninth encode byte is accepted and lasts exactly nine consecutive cycles, byte 0 first. Encode bytes that arrive during the replay, or that arrive in idle without the first marker, are ignored and start no replay.
- R4: A scanned sector is 9 stored parity bytes followed by 512 data bytes (521 in total). `scan_start` marks parity byte 0 and `scan_last` marks the final byte. Bytes that arrive while no sector is open, without `scan_start`, are ignored.
- R5: If all 521 bytes of a correctly sized sector are 0xFF, `sector_erased` is 1 for exactly the one cycle after the last byte and `dec_req` stays 0. This signals zero errors and no decode.
- R6: If any byte of the sector is not 0xFF, `dec_req` is 1 for the one cycle after the last byte and `sector_erased` stays 0.
- R7: `scan_nonblank` goes to 1 in the cycle after the first non-0xFF byte of a sector and holds until the next `scan_start`. A start byte of 0xFF clears it.
- R8: `scan_quick_reject` goes to 1 in the cycle after a non-0xFF byte at stream index 0, 9, 264 or 520 (parity byte 0, and data bytes 0, 255 and 511). A non-0xFF byte at any other index does not set it. It clears on `scan_start` and implies `scan_nonblank`.
- R9: A sector whose end marker falls on any stream index other than 520 yields `dec_req` and never `sector_erased`, even if every byte is 0xFF. Indices past 520 count toward this.
- R10: `sector_erased` and `dec_req` are never 1 together, and either one is 1 only in the cycle after an accepted end-marked byte.
- R11: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid | input | 1 | An encode parity byte is present |
| enc_first | input | 1 | This encode byte is parity byte 0 of a group |
| enc_byte | input | 8 | Encode parity byte from the generator |
| enc_out_valid | output | 1 | A replayed parity byte is present |
| enc_out_byte | output | 8 | Replayed parity byte, 0 when not valid |
| enc_out_blanked | output | 1 | The replayed group has been replaced by 0xFF |
| scan_valid | input | 1 | A read-back byte is present |
| scan_start | input | 1 | This byte is stored parity byte 0 of a sector |
| scan_last | input | 1 | This byte is the final byte of the sector |
| scan_byte | input | 8 | Read-back byte |
| scan_nonblank | output | 1 | Sticky: a non-0xFF byte was seen in this sector |
| scan_quick_reject | output | 1 | Sticky: a probe position held a non-0xFF byte |
| dec_req | output | 1 | One-cycle request to start the decoder |
| sector_erased | output | 1 | One-cycle report of a blank sector with zero errors |

## Verification
A wrong encode index or a stale mismatch flag shows up as a wrong replayed byte, or a wrong blanked flag, within the nine replay cycles that follow the ninth parity byte. A miscounting scan position shows up first on the quick-reject flag, in the cycle after the byte at a probe index. It shows up again at the verdict of every sector whose end marker is at index 520, because a miscount turns a blank sector into a decode request or the reverse. A sticky flag that fails to clear or set is visible one cycle after the offending byte, because both flags are compared against a model after every accepted byte.

// File: rtl/eef_pkg.sv
package eef_pkg;

    localparam int         PAR_BYTES   = 9;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_COLLECT,
        WR_EMIT
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_PARITY,
        RD_DATA,
        RD_VERDICT
    } rd_state_t;

    // Parity an all-0xFF sector produces, byte 0 first.
    function automatic logic [7:0] blank_parity(input int idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'hCD;
            1:       v = 8'h9D;
            2:       v = 8'h90;
            3:       v = 8'h58;
            4:       v = 8'hF4;
            5:       v = 8'h8B;
            6:       v = 8'hFF;
            7:       v = 8'hB7;
            8:       v = 8'h6F;
            default: v = ERASED_BYTE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/eef_par_subst.sv
module eef_par_subst
    import eef_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_first,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_subst
);

    localparam int IW = $clog2(PAR_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(PAR_BYTES - 1);

    wr_state_t     state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] cap_idx;
    logic [7:0]    hold_q [PAR_BYTES];
    logic          miss_q, subst_q;
    logic          accept, byte_miss, miss_now, group_done;

    // A start byte is taken unless a replay runs; follow-on bytes only while collecting.
    assign accept     = in_valid && ((in_first && state_q != WR_EMIT) || (state_q == WR_COLLECT));
    assign cap_idx    = in_first ? '0 : idx_q;
    assign byte_miss  = (in_byte != blank_parity(int'(cap_idx)));
    assign miss_now   = (in_first ? 1'b0 : miss_q) | byte_miss;
    assign group_done = accept && (cap_idx == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:    if (accept) state_d = group_done ? WR_EMIT : WR_COLLECT;
            WR_COLLECT: if (group_done) state_d = WR_EMIT;
            WR_EMIT:    if (idx_q == LAST_IDX) state_d = WR_IDLE;
            default:    state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            idx_q   <= '0;
            miss_q  <= 1'b0;
            subst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == WR_EMIT) begin
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            end else if (accept) begin
                idx_q  <= group_done ? '0 : cap_idx + 1'b1;
                miss_q <= miss_now;
                if (group_done) subst_q <= !miss_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAR_BYTES; i++) begin
            if (accept && cap_idx == IW'(i)) hold_q[i] <= in_byte;
        end
    end

    always_comb begin
        out_valid = (state_q == WR_EMIT);
        out_subst = out_valid && subst_q;
        out_byte  = '0;
        if (out_valid) out_byte = subst_q ? ERASED_BYTE : hold_q[idx_q];
    end

    // Checker: length of each replay run.
    logic [IW:0] run_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n) run_len_q <= '0;
        else        run_len_q <= out_valid ? run_len_q + 1'b1 : '0;
    end

    AST_REPLAY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> run_len_q == (IW+1)'(PAR_BYTES)); // R3
    AST_REPLAY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid)); // R3
    AST_BLANK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> $stable(out_subst)); // R1

endmodule

// File: rtl/eef_blank_scan.sv
module eef_blank_scan
    import eef_pkg::*;
#(
    parameter int DATA_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic       in_last,
    input  logic [7:0] in_byte,
    output logic       nonblank,
    output logic       quick_reject,
    output logic       dec_req,
    output logic       erased
);

    localparam int TOTAL  = PAR_BYTES + DATA_BYTES;
    localparam int CW     = $clog2(TOTAL + 1);
    localparam int MID    = PAR_BYTES + DATA_BYTES / 2 - 1;
    localparam int NPROBE = 4;

    function automatic int probe_at(input int g);
        int p;
        case (g)
            0:       p = 0;
            1:       p = PAR_BYTES;
            2:       p = MID;
            default: p = TOTAL - 1;
        endcase
        return p;
    endfunction

    rd_state_t         state_q, state_d, after_byte;
    logic [CW-1:0]     cnt_q, pos, cnt_next;
    logic [NPROBE-1:0] probe_hit;
    logic              nonblank_q, quick_q, badlen_q;
    logic              accept, byte_dirty, length_bad;

    assign pos        = in_start ? '0 : cnt_q;
    assign accept     = in_valid && (in_start || state_q == RD_PARITY || state_q == RD_DATA);
    assign byte_dirty = (in_byte != ERASED_BYTE);
    assign cnt_next   = (pos >= CW'(TOTAL)) ? pos : pos + 1'b1;
    assign length_bad = (in_last && pos != CW'(TOTAL - 1)) || (!in_start && cnt_q >= CW'(TOTAL));

    for (genvar g = 0; g < NPROBE; g++) begin : g_probe
        assign probe_hit[g] = (pos == CW'(probe_at(g)));
    end

    always_comb begin
        if (in_last)                        after_byte = RD_VERDICT;
        else if (pos < CW'(PAR_BYTES - 1))  after_byte = RD_PARITY;
        else                                after_byte = RD_DATA;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:            if (accept) state_d = after_byte;
            RD_PARITY, RD_DATA: if (accept) state_d = after_byte;
            RD_VERDICT:         state_d = accept ? after_byte : RD_IDLE;
            default:            state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RD_IDLE;
            cnt_q      <= '0;
            nonblank_q <= 1'b0;
            quick_q    <= 1'b0;
            badlen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q      <= cnt_next;
                nonblank_q <= (in_start ? 1'b0 : nonblank_q) | byte_dirty;
                quick_q    <= (in_start ? 1'b0 : quick_q) | (byte_dirty && (|probe_hit));
                badlen_q   <= (in_start ? 1'b0 : badlen_q) | length_bad;
            end
        end
    end

    always_comb begin
        nonblank     = nonblank_q;
        quick_reject = quick_q;
        erased       = (state_q == RD_VERDICT) && !nonblank_q && !badlen_q;
        dec_req      = (state_q == RD_VERDICT) && (nonblank_q || badlen_q);
    end

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(erased && dec_req)); // R10
    AST_VERDICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (erased || dec_req) |-> $past(in_valid && in_last)); // R10
    AST_ERASED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        erased |-> !nonblank); // R5
    AST_QUICK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        quick_reject |-> nonblank); // R8
    AST_NONBLANK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        nonblank && !(in_valid && in_start) |=> nonblank); // R7

endmodule

// File: rtl/erased_ecc_filter.sv
module erased_ecc_filter
    import eef_pkg::*;
#(
    parameter int DATA_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc_valid,
    input  logic       enc_first,
    input  logic [7:0] enc_byte,
    output logic       enc_out_valid,
    output logic [7:0] enc_out_byte,
    output logic       enc_out_blanked,
    input  logic       scan_valid,
    input  logic       scan_start,
    input  logic       scan_last,
    input  logic [7:0] scan_byte,
    output logic       scan_nonblank,
    output logic       scan_quick_reject,
    output logic       dec_req,
    output logic       sector_erased
);

    eef_par_subst u_subst (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_valid),
        .in_first  (enc_first),
        .in_byte   (enc_byte),
        .out_valid (enc_out_valid),
        .out_byte  (enc_out_byte),
        .out_subst (enc_out_blanked)
    );

    eef_blank_scan #(
        .DATA_BYTES (DATA_BYTES)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (scan_valid),
        .in_start     (scan_start),
        .in_last      (scan_last),
        .in_byte      (scan_byte),
        .nonblank     (scan_nonblank),
        .quick_reject (scan_quick_reject),
        .dec_req      (dec_req),
        .erased       (sector_erased)
    );

    AST_ENC_BYTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_out_valid |-> enc_out_byte == 8'h00); // R11

endmodule

// File: tb/erased_ecc_filter_bench.sv
module erased_ecc_filter_bench;

    localparam int DB  = 512;
    localparam int PB  = 9;
    localparam int TOT = PB + DB;
    localparam int MAXLEN = 540;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enc_valid, enc_first;
    logic [7:0] enc_byte;
    logic       enc_out_valid, enc_out_blanked;
    logic [7:0] enc_out_byte;
    logic       scan_valid, scan_start, scan_last;
    logic [7:0] scan_byte;
    logic       scan_nonblank, scan_quick_reject, dec_req, sector_erased;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] wbuf [PB];
    logic [7:0] sect [MAXLEN];

    always #5 clk = ~clk;

    erased_ecc_filter #(.DATA_BYTES(DB)) u_erased_ecc_filter (
        .clk(clk), .rst_n(rst_n),
        .enc_valid(enc_valid), .enc_first(enc_first), .enc_byte(enc_byte),
        .enc_out_valid(enc_out_valid), .enc_out_byte(enc_out_byte),
        .enc_out_blanked(enc_out_blanked),
        .scan_valid(scan_valid), .scan_start(scan_start), .scan_last(scan_last),
        .scan_byte(scan_byte), .scan_nonblank(scan_nonblank),
        .scan_quick_reject(scan_quick_reject), .dec_req(dec_req),
        .sector_erased(sector_erased)
    );

    function automatic logic [7:0] sig_byte(input int i);
        logic [7:0] v;
        case (i)
            0: v = 8'hCD; 1: v = 8'h9D; 2: v = 8'h90; 3: v = 8'h58; 4: v = 8'hF4;
            5: v = 8'h8B; 6: v = 8'hFF; 7: v = 8'hB7; default: v = 8'h6F;
        endcase
        return v;
    endfunction

    function automatic bit is_probe(input int i);
        return (i == 0) || (i == PB) || (i == PB + DB / 2 - 1) || (i == TOT - 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic load_sig();
        for (int i = 0; i < PB; i++) wbuf[i] = sig_byte(i);
    endtask

    // Sends wbuf as one group, checks the replay; disturb drives bytes during replay.
    task automatic wr_group(input bit disturb);
        bit match = 1'b1;
        for (int i = 0; i < PB; i++) if (wbuf[i] != sig_byte(i)) match = 1'b0;
        for (int i = 0; i < PB; i++) begin
            @(negedge clk);
            if (i > 0) chk("R3 no early replay", enc_out_valid, 0);
            enc_valid = 1'b1; enc_first = (i == 0); enc_byte = wbuf[i];
        end
        @(negedge clk);
        enc_valid = 1'b0; enc_first = 1'b0;
        for (int k = 0; k < PB; k++) begin
            chk("R3 replay valid", enc_out_valid, 1);
            if (match) begin
                chk("R1 byte blanked", enc_out_byte, 8'hFF);
                chk("R1 blanked flag", enc_out_blanked, 1);
            end else begin
                chk("R2 byte passed", enc_out_byte, wbuf[k]);
                chk("R2 blanked flag", enc_out_blanked, 0);
            end
            if (disturb) begin
                enc_valid = 1'b1; enc_first = (k % 2 == 0); enc_byte = 8'($urandom);
            end
            @(negedge clk);
        end
        enc_valid = 1'b0; enc_first = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R3 replay ends", enc_out_valid, 0);
            chk("R11 idle byte", enc_out_byte, 0);
            @(negedge clk);
        end
    endtask

    // Streams sect[0..len-1]; checks flags after every byte and the verdict.
    task automatic rd_sector(input int len, input bit gaps);
        bit enb = 1'b0;
        bit eqr = 1'b0;
        bit exp_erased;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && ($urandom % 8 == 0)) begin
                scan_valid = 1'b0; scan_start = 1'b0; scan_last = 1'b0;
                @(negedge clk);
                if (i > 0) chk("R7 gap holds", scan_nonblank, enb);
            end
            if (i > 0) begin
                chk("R7 nonblank", scan_nonblank, enb);
                chk("R8 quick", scan_quick_reject, eqr);
                chk("R10 no mid verdict", dec_req | sector_erased, 0);
            end
            scan_valid = 1'b1; scan_start = (i == 0); scan_last = (i == len - 1);
            scan_byte = sect[i];
            if (sect[i] != 8'hFF) begin
                enb = 1'b1;
                if (is_probe(i)) eqr = 1'b1;
            end
        end
        @(negedge clk);
        scan_valid = 1'b0; scan_start = 1'b0; scan_last = 1'b0;
        exp_erased = (len == TOT) && !enb;
        chk("R7 nonblank end", scan_nonblank, enb);
        chk("R8 quick end", scan_quick_reject, eqr);
        if (len != TOT) chk("R9 length verdict", dec_req, 1);
        chk(exp_erased ? "R5 erased" : "R6 erased low", sector_erased, exp_erased);
        chk(exp_erased ? "R5 no decode" : "R6 decode", dec_req, !exp_erased);
        @(negedge clk);
        chk("R10 verdict one cycle", dec_req | sector_erased, 0);
    endtask

    task automatic fill_blank();
        for (int i = 0; i < MAXLEN; i++) sect[i] = 8'hFF;
    endtask

    task automatic one_dirty(input int pos, input bit probe_expected);
        fill_blank();
        sect[pos] = 8'h00;
        rd_sector(TOT, 1'b0);
        chk(probe_expected ? "R8 probe sets" : "R8 non-probe clear",
            scan_quick_reject, probe_expected);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 1'b0;
        enc_valid = 0; enc_first = 0; enc_byte = 0;
        scan_valid = 0; scan_start = 0; scan_last = 0; scan_byte = 0;
        repeat (3) @(negedge clk);
        chk("R11 reset enc_out_valid", enc_out_valid, 0);
        chk("R11 reset enc_out_byte", enc_out_byte, 0);
        chk("R11 reset blanked", enc_out_blanked, 0);
        chk("R11 reset nonblank", scan_nonblank, 0);
        chk("R11 reset quick", scan_quick_reject, 0);
        chk("R11 reset verdict", dec_req | sector_erased, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", enc_out_valid | dec_req | sector_erased, 0);

        // Encode path, directed.
        load_sig(); wr_group(1'b0);                           // R1
        load_sig(); wbuf[8] = 8'h6E; wr_group(1'b0);          // R2 last byte off
        load_sig(); wbuf[0] = 8'hFF; wr_group(1'b0);          // R2 first byte off
        for (int i = 0; i < PB; i++) wbuf[i] = 8'hFF;
        wr_group(1'b0);                                       // R2 all ones
        load_sig(); wr_group(1'b1);                           // R3 disturbance
        // R3: bytes without first marker in idle start nothing.
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R3 stray ignored", enc_out_valid, 0);
            enc_valid = 1'b1; enc_first = 1'b0; enc_byte = sig_byte(k % PB);
        end
        @(negedge clk); enc_valid = 1'b0;
        repeat (2) begin @(negedge clk); chk("R3 stray ignored", enc_out_valid, 0); end

        // Encode path, random.
        for (int n = 0; n < 12; n++) begin
            int mode = int'($urandom % 3);
            load_sig();
            if (mode == 1) wbuf[$urandom % PB] ^= 8'(1 + ($urandom % 255));
            if (mode == 2) for (int i = 0; i < PB; i++) wbuf[i] = 8'($urandom);
            wr_group(n % 4 == 3);
        end

        // Scan path, directed.
        fill_blank(); rd_sector(TOT, 1'b0);                   // R5
        one_dirty(0, 1'b1);                                    // R8 parity 0
        one_dirty(5, 1'b0);                                    // R6 parity other
        one_dirty(PB, 1'b1);                                   // R8 data 0
        one_dirty(PB + 100, 1'b0);                             // R8 non-probe
        one_dirty(PB + DB / 2 - 1, 1'b1);                      // R8 data 255
        one_dirty(TOT - 1, 1'b1);                              // R8 data 511
        // R7: start byte of 0xFF clears the flags after a dirty sector.
        fill_blank(); rd_sector(TOT, 1'b0);
        // R4: stray bytes with no open sector are ignored.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            scan_valid = 1'b1; scan_start = 1'b0; scan_last = (k == 4); scan_byte = 8'h12;
        end
        @(negedge clk); scan_valid = 1'b0; scan_last = 1'b0;
        chk("R4 stray nonblank", scan_nonblank, 0);
        chk("R4 stray verdict", dec_req | sector_erased, 0);
        @(negedge clk);
        chk("R4 stray verdict", dec_req | sector_erased, 0);
        fill_blank(); rd_sector(TOT - 1, 1'b0);                // R9 short
        fill_blank(); rd_sector(TOT + 9, 1'b0);                // R9 long
        fill_blank(); rd_sector(1, 1'b0);                      // R9 single byte

        // Scan path, random.
        for (int n = 0; n < 14; n++) begin
            fill_blank();
            if ($urandom % 2 == 0) sect[$urandom % TOT] = 8'($urandom % 255);
            rd_sector(TOT, 1'b1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule